// File: doc/BRIEF.md
# Serial EEPROM Reload/Store Sequencer

This block moves 16-bit words between a small serial configuration EEPROM and a set of host registers. The host puts a word address in a pointer register and a data word in a data register, then sets a load bit to read a word into the data register or a save bit to write the data register out. While a transfer runs, both command bits read back as 1 and every other register is frozen. When both bits read 0 again, the transfer is finished. A hardware reset starts an automatic load of five words, at ascending addresses, into the configuration, base address and three station address registers. This load takes the same busy and lockout path. A static strap input can switch all EEPROM traffic off.

The serial side is a Microwire-style three-wire engine: chip select, serial clock, data in and data out. Every frame is a start bit, a 2-bit opcode and a 6-bit address, sent MSB first. A write-enable frame goes out before every write frame. After a write, chip select is raised again and the data-out line is polled until the device reports ready or a timeout counter expires.

The controller states are ST_RESET, ST_IDLE, ST_LAUNCH, ST_SHIFT, ST_DESEL and ST_POLL. The transitions are:
- reset-entry: ST_RESET goes to ST_LAUNCH when the strap is high, and to ST_IDLE when it is low.
- command-accept: ST_IDLE goes to ST_LAUNCH on a valid host command.
- frame-start: ST_LAUNCH goes to ST_SHIFT.
- frame-end: ST_SHIFT goes to ST_DESEL when the shifter finishes.
- chain: ST_DESEL goes on a divider tick to ST_LAUNCH for the next boot word, or for the write frame after the write-enable frame.
- poll-entry: ST_DESEL goes to ST_POLL after a write frame.
- finish: ST_DESEL goes to ST_IDLE.
- ready-or-timeout: ST_POLL goes to ST_DESEL.

Top module: `eeprom_seq`

## Requirements
- R1: After reset with the strap (ee_en) high, the block reads EEPROM words BOOT_BASE+0 to BOOT_BASE+4 in ascending order into register addresses 3 to 7. Address 3 is configuration, address 4 is base address, and addresses 5 to 7 are the station address words.
- R2: Writing the control register (address 0) with bits [1:0] = 01 reads the EEPROM word at pointer[5:0] into the data register (address 2). The busy flag starts in the cycle after the write.
- R3: Writing the control register with bits [1:0] = 10 first sends a write-enable frame: start bit 1, opcode 00, address 110000. It then sends a write frame: start bit 1, opcode 01, pointer[5:0], and the 16 data-register bits MSB first. The EEPROM ends up holding the data word.
- R4: While any transfer runs, including the reset load, control bits [1:0] read 11. They read 00 when the block is idle.
- R5: While busy, reads of addresses 1 to 7 return 0 and writes to any address are dropped.
- R6: With the strap low, chip select never rises and control writes have no effect. Configuration keeps CFG_RST, base address keeps BASE_RST, and the station address words keep 0.
- R7: A control write with bits [1:0] = 11 is ignored: no busy, and no chip select.
- R8: The data-in line changes only while the serial clock is low. Read data is sampled MSB first at the rising serial-clock edges 10 to 25 of a read frame.
- R9: The serial clock period is 2*CLK_DIV system clocks.
- R10: After a write frame, chip select drops and rises again. The block then polls data-out until it reads 1, or until POLL_LIMIT cycles have passed, and then ends the transfer.
- R11: Only pointer bits [5:0] select the EEPROM word. The upper pointer bits are stored and read back, but they are not used for addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_en | input | 1 | Static strap; low disables all EEPROM traffic |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 3 | Register address (0 control, 1 pointer, 2 data, 3..7 loaded words) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from reg_addr) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready flag from the EEPROM |

## Verification
The bench attacks lockout while busy by writing the pointer during the boot load and the data register during a store. A design that leaks these writes would load a different word or store the wrong data. It writes both command bits together: a design that decodes either bit alone would start a frame, and the bench counts chip-select rises to see it. It makes the write-ready poll never answer, so a design without the timeout hangs, and one that skips polling finishes too fast. It also runs a store against an EEPROM model that forgets write-enable after each write, so a design that sends write-enable only once loses the second store.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_IDLE,
        ST_LAUNCH,
        ST_SHIFT,
        ST_DESEL,
        ST_POLL
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_BOOT,
        OP_LOAD,
        OP_EWEN,
        OP_WRITE,
        OP_TAIL
    } seq_op_t;

    localparam int FRAME_BITS = 25;
    localparam int HDR_BITS   = 9;
    localparam int WORD_BITS  = 16;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_EWEN  = 2'b00;
    localparam logic [5:0] EWEN_ADDR = 6'b110000;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_PTR  = 3'd1;
    localparam logic [2:0] RA_DATA = 3'd2;

endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CW'(DIV - 1));

endmodule

// File: rtl/mw_shifter.sv
module mw_shifter #(
    parameter int NB = 25,
    parameter int WB = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       start,
    input  logic [$clog2(NB+1)-1:0]    nbits,
    input  logic [NB-1:0]              frame,
    input  logic                       sdo,
    output logic                       sk,
    output logic                       sdi,
    output logic                       done,
    output logic [WB-1:0]              rx
);
    localparam int LW = $clog2(NB + 1);

    logic [NB-1:0] sh;
    logic [LW-1:0] left;
    logic          active;
    logic          phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            left   <= '0;
            active <= 1'b0;
            phase  <= 1'b0;
            sk     <= 1'b0;
            done   <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh     <= frame;
                left   <= nbits;
                active <= 1'b1;
                phase  <= 1'b0;
                sk     <= 1'b0;
            end else if (active && tick) begin
                if (!phase) begin
                    sk    <= 1'b1;
                    rx    <= {rx[WB-2:0], sdo};
                    phase <= 1'b1;
                end else begin
                    sk    <= 1'b0;
                    phase <= 1'b0;
                    sh    <= sh << 1;
                    left  <= left - 1'b1;
                    if (left == LW'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    assign sdi = active & sh[NB-1];

    AST_DI_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sk |-> $stable(sdi)); // R8
    AST_SK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(sk)); // R9

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
    import eeprom_seq_pkg::*;
#(
    parameter int          CLK_DIV    = 4,
    parameter int          POLL_LIMIT = 4096,
    parameter int          BOOT_BASE  = 0,
    parameter logic [15:0] CFG_RST    = 16'h0030,
    parameter logic [15:0] BASE_RST   = 16'h0300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ee_en,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do
);
    localparam int          BOOT_WORDS = 5;
    localparam int          IW         = $clog2(BOOT_WORDS);
    localparam int          PCW        = $clog2(POLL_LIMIT + 1);
    localparam int          LW         = $clog2(FRAME_BITS + 1);
    localparam logic [5:0]  BOOT_A     = 6'(BOOT_BASE);

    seq_state_t        state, nstate;
    seq_op_t           op;
    logic [IW-1:0]     idx;
    logic [PCW-1:0]    pcnt;
    logic              tick;
    logic              sh_done;
    logic [15:0]       rx;
    logic [FRAME_BITS-1:0] frame;
    logic [LW-1:0]     nbits;

    logic [15:0]       ptr_q;
    logic [15:0]       data_q;
    logic [15:0]       boot_q [BOOT_WORDS];

    logic busy, wr_any, ctrl_wr, go_load, go_store, poll_end;

    assign busy     = (state != ST_IDLE);
    assign wr_any   = reg_sel && reg_we && !busy;
    assign ctrl_wr  = wr_any && (reg_addr == RA_CTRL);
    assign go_load  = ctrl_wr && ee_en && (reg_wdata[1:0] == 2'b01);
    assign go_store = ctrl_wr && ee_en && (reg_wdata[1:0] == 2'b10);
    assign poll_end = ee_do || (pcnt == PCW'(POLL_LIMIT - 1));

    mw_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        frame = '0;
        nbits = LW'(FRAME_BITS);
        unique case (op)
            OP_BOOT:  frame = {1'b1, OPC_READ, 6'(BOOT_A + 6'(idx)), 16'h0000};
            OP_LOAD:  frame = {1'b1, OPC_READ, ptr_q[5:0], 16'h0000};
            OP_EWEN: begin
                frame = {1'b1, OPC_EWEN, EWEN_ADDR, 16'h0000};
                nbits = LW'(HDR_BITS);
            end
            OP_WRITE: frame = {1'b1, OPC_WRITE, ptr_q[5:0], data_q};
            OP_TAIL:  frame = '0;
            default:  frame = '0;
        endcase
    end

    mw_shifter #(.NB(FRAME_BITS), .WB(WORD_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (state == ST_LAUNCH),
        .nbits (nbits),
        .frame (frame),
        .sdo   (ee_do),
        .sk    (ee_sk),
        .sdi   (ee_di),
        .done  (sh_done),
        .rx    (rx)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_RESET:  nstate = ee_en ? ST_LAUNCH : ST_IDLE;
            ST_IDLE:   if (go_load || go_store) nstate = ST_LAUNCH;
            ST_LAUNCH: nstate = ST_SHIFT;
            ST_SHIFT:  if (sh_done) nstate = ST_DESEL;
            ST_DESEL: begin
                if (tick) begin
                    unique case (op)
                        OP_BOOT:  nstate = (idx == IW'(BOOT_WORDS - 1)) ? ST_IDLE : ST_LAUNCH;
                        OP_LOAD:  nstate = ST_IDLE;
                        OP_EWEN:  nstate = ST_LAUNCH;
                        OP_WRITE: nstate = ST_POLL;
                        OP_TAIL:  nstate = ST_IDLE;
                        default:  nstate = ST_IDLE;
                    endcase
                end
            end
            ST_POLL:   if (poll_end) nstate = ST_DESEL;
            default:   nstate = ST_IDLE;
        endcase
    end

    // state register with operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
            op    <= OP_BOOT;
            idx   <= '0;
            pcnt  <= '0;
        end else begin
            state <= nstate;
            pcnt  <= (state == ST_POLL) ? pcnt + 1'b1 : '0;
            if (state == ST_IDLE) begin
                if (go_load)  op <= OP_LOAD;
                if (go_store) op <= OP_EWEN;
            end
            if (state == ST_DESEL && tick) begin
                unique case (op)
                    OP_BOOT:  idx <= idx + 1'b1;
                    OP_EWEN:  op  <= OP_WRITE;
                    OP_WRITE: op  <= OP_TAIL;
                    default:  ;
                endcase
            end
        end
    end

    // outputs and register file
    assign ee_cs = (state == ST_LAUNCH) || (state == ST_SHIFT) || (state == ST_POLL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            data_q <= '0;
            for (int i = 0; i < BOOT_WORDS; i++) begin
                boot_q[i] <= (i == 0) ? CFG_RST : (i == 1) ? BASE_RST : 16'h0000;
            end
        end else begin
            if (wr_any && reg_addr == RA_PTR)  ptr_q  <= reg_wdata;
            if (wr_any && reg_addr == RA_DATA) data_q <= reg_wdata;
            if (wr_any && reg_addr >= 3'd3)    boot_q[reg_addr - 3'd3] <= reg_wdata;
            if (state == ST_SHIFT && sh_done) begin
                if (op == OP_BOOT) boot_q[idx] <= rx;
                if (op == OP_LOAD) data_q      <= rx;
            end
        end
    end

    always_comb begin
        reg_rdata = 16'h0000;
        if (reg_addr == RA_CTRL) begin
            reg_rdata = {14'd0, busy, busy};
        end else if (!busy) begin
            unique case (reg_addr)
                RA_PTR:  reg_rdata = ptr_q;
                RA_DATA: reg_rdata = data_q;
                default: reg_rdata = boot_q[reg_addr - 3'd3];
            endcase
        end
    end

    AST_STRAP_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_en |-> !ee_cs); // R6
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_we && !busy && reg_addr == RA_CTRL && ee_en && reg_wdata[1:0] == 2'b01) |=> busy); // R2
    AST_PAIR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_we && !busy && reg_addr == RA_CTRL && reg_wdata[1:0] == 2'b11) |=> !busy); // R7
    AST_LOCK_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_sel && reg_we && reg_addr == RA_PTR) |=> $stable(ptr_q)); // R5
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL) |-> (pcnt < PCW'(POLL_LIMIT))); // R10

endmodule

// File: tb/eeprom_seq_tb.sv
module eeprom_seq_tb_top;

    localparam int DIV   = 2;
    localparam int PLIM  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_en = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    eeprom_seq #(.CLK_DIV(DIV), .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .ee_en(ee_en),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [64];
    logic [15:0] shadow [64];
    int  cyc = 0;
    int  cs_rises = 0;
    int  sk_per = 0;
    int  last_rise = -1;
    int  busy_delay = 20;
    int  busy_cnt = 0;
    bit  kill_busy = 0;
    int  bitcnt = 0;
    logic [8:0]  cmd = '0;
    logic [15:0] wsh = '0;
    bit  wen = 0;
    bit  rd_on = 0;
    logic rd_bit = 1'b0;
    bit  cs_p = 0, sk_p = 0;
    int  rlog [16];
    int  rcount = 0;

    function automatic logic [15:0] init_word(input int a);
        return 16'((a * 16'h0123) ^ 16'hC35A);
    endfunction

    assign ee_do = rd_on ? rd_bit : (busy_cnt == 0);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (ee_cs && !cs_p) begin
            cs_rises++;
            bitcnt = 0; cmd = '0; rd_on = 0; last_rise = -1;
        end else if (ee_cs && ee_sk && !sk_p) begin
            if (last_rise >= 0) sk_per = cyc - last_rise;
            last_rise = cyc;
            if (bitcnt < 9) cmd = {cmd[7:0], ee_di};
            else wsh = {wsh[14:0], ee_di};
            bitcnt++;
            if (bitcnt == 9 && cmd[8] && cmd[7:6] == 2'b10 && rcount < 16) begin
                rlog[rcount] = int'(cmd[5:0]);
                rcount++;
            end
        end else if (ee_cs && !ee_sk && sk_p && bitcnt >= 9 && bitcnt < 25
                     && cmd[8] && cmd[7:6] == 2'b10) begin
            rd_on = 1;
            rd_bit = mem[cmd[5:0]][24 - bitcnt];
        end
        if (!ee_cs && cs_p) begin
            rd_on = 0;
            if (bitcnt == 9 && cmd == 9'b1_00_110000) wen = 1;
            if (bitcnt == 25 && cmd[8] && cmd[7:6] == 2'b01 && wen) begin
                mem[cmd[5:0]] = wsh;
                wen = 0;
                busy_cnt = busy_delay;
            end
        end
        if (kill_busy) busy_cnt = 0;
        else if (busy_cnt != 0) busy_cnt--;
        cs_p = ee_cs;
        sk_p = ee_sk;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_sel = 1; reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
        reg_sel = 0;
    endtask

    task automatic wait_idle(output int n, output bit ok);
        logic [15:0] v;
        ok = 0; n = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd0, v);
            n++;
            if (v[1:0] == 2'b00) begin ok = 1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] v, d, p;
        int n, c0;
        bit ok;
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) begin
            mem[i] = init_word(i);
            shadow[i] = init_word(i);
        end

        // reset load
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        rd(3'd0, v);  chk("R4 boot busy bits", 32'(v[1:0]), 32'd3);
        rd(3'd3, v);  chk("R5 locked read", 32'(v), 32'd0);
        wr(3'd1, 16'hBEEF);
        wait_idle(n, ok); chk("R1 boot completes", 32'(ok), 32'd1);
        rd(3'd1, v);  chk("R5 write during busy dropped", 32'(v), 32'd0);
        for (int i = 0; i < 5; i++) begin
            rd(3'(3 + i), v);
            chk("R1 boot word", 32'(v), 32'(init_word(i)));
            chk("R1 boot order", 32'(rlog[i]), 32'(i));
        end
        chk("R9 sk period", 32'(sk_per), 32'(2 * DIV));

        // random loads and stores
        for (int it = 0; it < 12; it++) begin
            p = 16'($urandom);
            if ($urandom % 2 == 0) begin
                wr(3'd1, p); wr(3'd0, 16'h0001);
                rd(3'd0, v); chk("R4 load busy bits", 32'(v[1:0]), 32'd3);
                wait_idle(n, ok);
                rd(3'd2, v); chk("R2 R11 loaded word", 32'(v), 32'(shadow[p[5:0]]));
                rd(3'd1, v); chk("R11 pointer readback", 32'(v), 32'(p));
            end else begin
                d = 16'($urandom);
                wr(3'd2, d); wr(3'd1, p); wr(3'd0, 16'h0002);
                rd(3'd0, v); chk("R4 store busy bits", 32'(v[1:0]), 32'd3);
                wr(3'd2, ~d);
                wait_idle(n, ok);
                chk("R10 ready poll ends early", 32'(n < 250), 32'd1);
                chk("R3 eeprom holds word", 32'(mem[p[5:0]]), 32'(d));
                shadow[p[5:0]] = d;
                rd(3'd2, v); chk("R5 data write during store dropped", 32'(v), 32'(d));
            end
        end

        // both bits together
        c0 = cs_rises;
        wr(3'd0, 16'h0003);
        rd(3'd0, v); chk("R7 pair ignored busy", 32'(v[1:0]), 32'd0);
        repeat (20) @(negedge clk);
        chk("R7 pair no chip select", 32'(cs_rises), 32'(c0));

        // poll timeout
        busy_delay = 100000;
        wr(3'd2, 16'h1234); wr(3'd1, 16'h0009); wr(3'd0, 16'h0002);
        wait_idle(n, ok);
        chk("R10 timeout ends transfer", 32'(ok), 32'd1);
        chk("R10 timeout waited", 32'(n >= PLIM), 32'd1);
        chk("R3 timeout store data", 32'(mem[9]), 32'h1234);
        kill_busy = 1; @(negedge clk); kill_busy = 0; busy_delay = 20;

        // strap low
        ee_en = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        c0 = cs_rises;
        rst_n = 1;
        repeat (4) @(negedge clk);
        rd(3'd0, v); chk("R6 strap idle", 32'(v[1:0]), 32'd0);
        rd(3'd3, v); chk("R6 cfg default", 32'(v), 32'h0030);
        rd(3'd4, v); chk("R6 base default", 32'(v), 32'h0300);
        rd(3'd6, v); chk("R6 station default", 32'(v), 32'h0000);
        wr(3'd0, 16'h0001);
        rd(3'd0, v); chk("R6 load ignored", 32'(v[1:0]), 32'd0);
        repeat (50) @(negedge clk);
        chk("R6 no chip select", 32'(cs_rises), 32'(c0));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule